// File: doc/BRIEF.md
# E1 Timeslot-0 Overhead Formatter

This block sits on the transmit side of an E1 path. It takes a serial payload stream that has already been framed, with one bit per valid cycle, and rewrites the overhead bits of timeslot 0 so that the line carries a proper 16-frame CRC-4 multiframe. The upstream sequencer supplies a frame number (0 to 15 within the multiframe) and a bit number (0 to 255 within the frame) with every bit. Bit number 0 is the first bit on the line. It is TS0 bit 1, the most significant bit of the slot. Bit numbers 0 to 7 therefore carry TS0 bits 1 to 8.

Four independent enables control the rewrite. One writes the alignment word in even frames and the fixed bit 2 in odd frames. One writes the multiframe alignment sequence in bit 1 of odd frames 1 to 11. One writes the CRC-4 check bits in bit 1 of the even frames. One writes the far-end block error bits in bit 1 of frames 13 and 15. When an enable is clear, its positions carry the incoming bit unchanged.

The block computes CRC-4 over each submultiframe as that submultiframe is sent. It places the check bits in the submultiframe that follows. Separate pulse inputs report CRC-4 errors that the receiver detected in submultiframe I and in submultiframe II. Each pulse is held until the matching error bit has been sent.

Top module: `e1_ts0_formatter`

## Requirements
- R1: With `en_fas` high, in even frames bit numbers 1 to 7 (TS0 bits 2 to 8) are sent as 0,0,1,1,0,1,1 in that order.
- R2: With `en_fas` high, in odd frames bit number 1 (TS0 bit 2) is sent as 1.
- R3: With `en_mfas` high, bit number 0 of frames 1, 3, 5, 7, 9 and 11 is sent as 0, 0, 1, 0, 1, 1 respectively.
- R4: With `en_crc` high, bit number 0 of frames 0, 2, 4 and 6 carries C1 to C4, and the same bit of frames 8, 10, 12 and 14 carries C1 to C4. C1 to C4 are the remainder, most significant term first, of the previous submultiframe's sent bits multiplied by x^4 and divided by x^4+x+1. Bit number 0 of every even frame counts as 0 in this division, whatever enables are set. The check bits are zero until the first submultiframe has completed.
- R5: With `en_ebit` high, bit number 0 of frame 13 is sent as 0 if a submultiframe-I error pulse arrived after the previous frame-13 slot, and as 1 otherwise. The frame-13 slot clears the held error whether or not `en_ebit` is set. A pulse that arrives in the same cycle as the slot is kept for the next frame-13 slot.
- R6: The rule of R5 applies to frame 15 and the submultiframe-II error pulse.
- R7: Every bit not rewritten by R1 to R6 is sent equal to `din`. This covers all bits with bit number 8 or higher, bits 2 to 7 of odd frames, and every overhead position whose enable is clear.
- R8: Each valid input bit appears on `dout`, with `dout_valid` high, exactly one cycle later. A cycle with `bit_valid` low gives `dout_valid` low in the next cycle and changes no internal state.
- R9: During and after reset, `dout_valid` and `dout` are 0, no error is held, and the held check bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | Input bit qualifier |
| frame_idx | input | 4 | Frame number in the multiframe, 0 to 15 |
| bit_idx | input | 8 | Bit number in the frame, 0 is sent first |
| din | input | 1 | Payload bit |
| en_fas | input | 1 | Enable for the alignment word and the odd-frame bit 2 |
| en_mfas | input | 1 | Enable for the multiframe alignment sequence |
| en_crc | input | 1 | Enable for CRC-4 check bit insertion |
| en_ebit | input | 1 | Enable for far-end block error bit insertion |
| rx_crc_err_smf1 | input | 1 | Pulse: received CRC-4 error in submultiframe I |
| rx_crc_err_smf2 | input | 1 | Pulse: received CRC-4 error in submultiframe II |
| dout_valid | output | 1 | Output bit qualifier |
| dout | output | 1 | Formatted line bit |

## Verification
Each formatted bit is due exactly one cycle after its input bit. The bench drives a bit on a falling edge and compares the registered output on the next falling edge against a value that its model computed at drive time. A CRC-4 result is due over the whole following submultiframe. The model recomputes it by long division on the queue of bits it saw sent, so a check-bit error is caught at the first C slot afterwards. An error pulse is due at the next frame-13 or frame-15 slot. The schedule places pulses well ahead of a slot, exactly on a slot, and with the insert enable clear, so that the hold, the clearing and the carry-over are each observed on `dout`.

// File: rtl/e1ts0_pkg.sv
`timescale 1ns/1ps
package e1ts0_pkg;

  localparam int TS_BITS = 8;
  localparam int CRC_W   = 4;

  // Alignment word bit for TS0 bit numbers 1..7 (bits 2..8 of the slot)
  function automatic logic fas_bit(input logic [2:0] pos);
    logic [6:0] pat;
    pat = 7'b0011011;
    return pat[3'd7 - pos];
  endfunction

  // Multiframe alignment bit, k = odd frame number / 2 (0..5)
  function automatic logic mfas_bit(input logic [2:0] k);
    case (k)
      3'd2, 3'd4, 3'd5: return 1'b1;
      default:          return 1'b0;
    endcase
  endfunction

  // One serial step of the x^4+x+1 remainder register
  function automatic logic [CRC_W-1:0] crc4_step(input logic [CRC_W-1:0] c,
                                                 input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ {2'b00, fb, fb};
  endfunction

endpackage

// File: rtl/e1ts0_crc4.sv
`timescale 1ns/1ps
module e1ts0_crc4
  import e1ts0_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             bit_in,
  input  logic             smf_end,
  output logic [CRC_W-1:0] crc_run,
  output logic [CRC_W-1:0] crc_held
);

  logic [CRC_W-1:0] crc_nxt;
  assign crc_nxt = crc4_step(crc_run, bit_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_run  <= '0;
      crc_held <= '0;
    end else if (step) begin
      if (smf_end) begin
        crc_held <= crc_nxt;
        crc_run  <= '0;
      end else begin
        crc_run  <= crc_nxt;
      end
    end
  end

endmodule

// File: rtl/e1ts0_ebit.sv
`timescale 1ns/1ps
module e1ts0_ebit #(
  parameter int CHANNELS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] err_pulse,
  input  logic [CHANNELS-1:0] slot_fire,
  output logic [CHANNELS-1:0] pend
);

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rst_n)            pend[g] <= 1'b0;
      else if (err_pulse[g]) pend[g] <= 1'b1;
      else if (slot_fire[g]) pend[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/e1_ts0_formatter.sv
`timescale 1ns/1ps
module e1_ts0_formatter
  import e1ts0_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int MF_FRAMES  = 16,
  localparam int BIT_W     = $clog2(FRAME_BITS),
  localparam int FR_W      = $clog2(MF_FRAMES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_valid,
  input  logic [FR_W-1:0] frame_idx,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic            din,
  input  logic            en_fas,
  input  logic            en_mfas,
  input  logic            en_crc,
  input  logic            en_ebit,
  input  logic            rx_crc_err_smf1,
  input  logic            rx_crc_err_smf2,
  output logic            dout_valid,
  output logic            dout
);

  localparam logic [FR_W-1:0]  MFAS_LAST = FR_W'(11);
  localparam logic [FR_W-1:0]  E1_FRAME  = FR_W'(MF_FRAMES - 3);
  localparam logic [FR_W-1:0]  E2_FRAME  = FR_W'(MF_FRAMES - 1);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_BITS - 1);

  // Named position events
  logic       odd_frame, bit1_pos, bit2_pos, fas_pos;
  logic       c_pos, mf_pos;
  logic [1:0] e_pos, e_fire, e_pend;
  logic       smf_end;
  logic [CRC_W-1:0] crc_run, crc_held;
  logic       fmt_bit, crc_bit;

  assign odd_frame = frame_idx[0];
  assign bit1_pos  = (bit_idx == '0);
  assign bit2_pos  = (bit_idx == BIT_W'(1));
  assign fas_pos   = !odd_frame && (bit_idx != '0) && (bit_idx < BIT_W'(TS_BITS));
  assign c_pos     = bit1_pos && !odd_frame;
  assign mf_pos    = bit1_pos && odd_frame && (frame_idx <= MFAS_LAST);
  assign e_pos[0]  = bit1_pos && (frame_idx == E1_FRAME);
  assign e_pos[1]  = bit1_pos && (frame_idx == E2_FRAME);
  assign e_fire    = {2{bit_valid}} & e_pos;
  assign smf_end   = bit_valid && (bit_idx == LAST_BIT) && (&frame_idx[FR_W-2:0]);

  always_comb begin
    fmt_bit = din;
    if (en_fas && fas_pos)
      fmt_bit = fas_bit(bit_idx[2:0]);
    if (en_fas && odd_frame && bit2_pos)
      fmt_bit = 1'b1;
    if (en_mfas && mf_pos)
      fmt_bit = mfas_bit(frame_idx[3:1]);
    if (en_crc && c_pos)
      fmt_bit = crc_held[~frame_idx[2:1]];
    if (en_ebit && e_pos[0])
      fmt_bit = !e_pend[0];
    if (en_ebit && e_pos[1])
      fmt_bit = !e_pend[1];
  end

  // C positions enter the division as zero
  assign crc_bit = c_pos ? 1'b0 : fmt_bit;

  e1ts0_crc4 i_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (bit_valid),
    .bit_in   (crc_bit),
    .smf_end  (smf_end),
    .crc_run  (crc_run),
    .crc_held (crc_held)
  );

  e1ts0_ebit #(.CHANNELS(2)) i_ebit (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_pulse ({rx_crc_err_smf2, rx_crc_err_smf1}),
    .slot_fire (e_fire),
    .pend      (e_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_valid <= 1'b0;
      dout       <= 1'b0;
    end else begin
      dout_valid <= bit_valid;
      if (bit_valid) dout <= fmt_bit;
    end
  end

endmodule

// File: rtl/e1ts0_checker.sv
`timescale 1ns/1ps
module e1ts0_checker #(
  parameter int BIT_W = 8,
  parameter int FR_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic [FR_W-1:0]  frame_idx,
  input logic [BIT_W-1:0] bit_idx,
  input logic             din,
  input logic             en_fas,
  input logic             en_mfas,
  input logic             en_crc,
  input logic             en_ebit,
  input logic             dout_valid,
  input logic             dout,
  input logic [1:0]       e_pend,
  input logic [3:0]       crc_run,
  input logic             smf_end
);

  a_r1_fas_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && en_fas && !frame_idx[0] && bit_idx == BIT_W'(2)) |=> !dout);

  a_r1_fas_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && en_fas && !frame_idx[0] && bit_idx == BIT_W'(7)) |=> dout);

  a_r2_nfas_bit2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && en_fas && frame_idx[0] && bit_idx == BIT_W'(1)) |=> dout);

  a_r3_mfas_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && en_mfas && frame_idx == FR_W'(1) && bit_idx == '0) |=> !dout);

  a_r4_crc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    smf_end |=> (crc_run == 4'd0));

  a_r5_ebit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && en_ebit && frame_idx == FR_W'(13) && bit_idx == '0 && e_pend[0]) |=> !dout);

  a_r6_ebit_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && en_ebit && frame_idx == FR_W'(15) && bit_idx == '0 && !e_pend[1]) |=> dout);

  a_r7_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_idx >= BIT_W'(8)) |=> (dout == $past(din)));

  a_r8_valid: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dout_valid == $past(bit_valid)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(dout));

endmodule

bind e1_ts0_formatter e1ts0_checker #(.BIT_W(BIT_W), .FR_W(FR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_valid  (bit_valid),
  .frame_idx  (frame_idx),
  .bit_idx    (bit_idx),
  .din        (din),
  .en_fas     (en_fas),
  .en_mfas    (en_mfas),
  .en_crc     (en_crc),
  .en_ebit    (en_ebit),
  .dout_valid (dout_valid),
  .dout       (dout),
  .e_pend     (e_pend),
  .crc_run    (crc_run),
  .smf_end    (smf_end)
);

// File: tb/test_e1_ts0_formatter.sv
`timescale 1ns/1ps
module test_e1_ts0_formatter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic [3:0] frame_idx = '0;
  logic [7:0] bit_idx = '0;
  logic din = 1'b0;
  logic en_fas = 1'b0, en_mfas = 1'b0, en_crc = 1'b0, en_ebit = 1'b0;
  logic rx_crc_err_smf1 = 1'b0, rx_crc_err_smf2 = 1'b0;
  logic dout_valid, dout;

  always #2.5 clk = ~clk;

  e1_ts0_formatter i_e1_ts0_formatter (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .frame_idx(frame_idx),
    .bit_idx(bit_idx), .din(din), .en_fas(en_fas), .en_mfas(en_mfas),
    .en_crc(en_crc), .en_ebit(en_ebit), .rx_crc_err_smf1(rx_crc_err_smf1),
    .rx_crc_err_smf2(rx_crc_err_smf2), .dout_valid(dout_valid), .dout(dout)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // reference state
  bit   m_pend1 = 0, m_pend2 = 0;
  bit   m_crc[4] = '{0, 0, 0, 0};
  bit   m_sent[$];
  bit   m_last = 0;

  function automatic void long_div(input bit msg[$], output bit r[4]);
    int acc;
    acc = 0;
    for (int i = 0; i < msg.size() + 4; i++) begin
      acc = (acc << 1) | ((i < msg.size()) ? int'(msg[i]) : 0);
      if (acc & 16) acc = acc ^ 19;
    end
    for (int j = 0; j < 4; j++) r[j] = bit'((acc >> (3 - j)) & 1);
  endfunction

  function automatic string req_of(int fr, int bt);
    if (bt == 0) begin
      if (fr % 2 == 0) return "R4";
      if (fr == 13) return "R5";
      if (fr == 15) return "R6";
      return "R3";
    end
    if (bt < 8 && fr % 2 == 0) return "R1";
    if (bt == 1) return "R2";
    return "R7";
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // one bit time: drive at falling edge, compare at the next falling edge
  task automatic step(input bit v, input int fr, input int bt, input bit d,
                      input bit p1, input bit p2);
    bit exp;
    bit fas_word[7];
    bit mf_seq[6];
    fas_word = '{0, 0, 1, 1, 0, 1, 1};
    mf_seq   = '{0, 0, 1, 0, 1, 1};
    exp = d;
    if (bt >= 1 && bt <= 7 && fr % 2 == 0 && en_fas) exp = fas_word[bt-1];
    if (bt == 1 && fr % 2 == 1 && en_fas) exp = 1;
    if (bt == 0 && fr % 2 == 1 && fr <= 11 && en_mfas) exp = mf_seq[fr/2];
    if (bt == 0 && fr % 2 == 0 && en_crc) exp = m_crc[(fr % 8) / 2];
    if (bt == 0 && fr == 13 && en_ebit) exp = !m_pend1;
    if (bt == 0 && fr == 15 && en_ebit) exp = !m_pend2;
    bit_valid = v; frame_idx = 4'(fr); bit_idx = 8'(bt); din = d;
    rx_crc_err_smf1 = p1; rx_crc_err_smf2 = p2;
    if (v) begin
      m_sent.push_back((bt == 0 && fr % 2 == 0) ? 1'b0 : exp);
      if (bt == 255 && fr % 8 == 7) begin
        long_div(m_sent, m_crc);
        m_sent.delete();
      end
      if (bt == 0 && fr == 13) m_pend1 = 0;
      if (bt == 0 && fr == 15) m_pend2 = 0;
    end
    if (p1) m_pend1 = 1;
    if (p2) m_pend2 = 1;
    @(posedge clk);
    @(negedge clk);
    check("R8", dout_valid, v);
    if (v) begin
      check(req_of(fr, bt), dout, exp);
      m_last = exp;
    end else begin
      check("R8", dout, m_last);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R9", dout_valid, 0);
    check("R9", dout, 0);
    rst_n = 1'b1;
    for (int mf = 0; mf < 7; mf++) begin
      en_fas  = (mf != 2);
      en_mfas = (mf != 3);
      en_crc  = (mf != 3);
      en_ebit = (mf != 4);
      for (int fr = 0; fr < 16; fr++) begin
        for (int bt = 0; bt < 256; bt++) begin
          bit p1, p2;
          p1 = ((mf == 1 || mf == 4) && fr == 2 && bt == 50) ||
               (mf == 5 && fr == 13 && bt == 0);
          p2 = ((mf == 1 || mf == 4) && fr == 9 && bt == 10) ||
               (mf == 2 && fr == 15 && bt == 0);
          if (bt == 100 && fr % 5 == 3)
            step(0, fr, bt, 1'($urandom), 0, 0);
          step(1, fr, bt, 1'($urandom), p1, p2);
        end
      end
    end
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule